// File: doc/BRIEF.md
# DSP Data Address Generator

This block forms data-memory addresses for a signal-processing core. Each cycle the core presents an operation code, a 16-bit immediate and a 16-bit word fetched from memory. The block answers with an effective address for that cycle. For some operations it also updates its internal pointer state at the next clock edge.

Two access styles are provided. Paged access joins a stored 9-bit page number with a 7-bit offset taken from the immediate. Pointer access emits the content of one of eight 16-bit pointer registers, chosen by a 3-bit selector. It can then post-modify that register in one of four ways:
- a plain step of one,
- a step by a stored index,
- a modulo step inside a circular buffer described by a stored base and length,
- a reverse-carry step for FFT reordering.

The selected pointer can also be loaded, adjusted by an immediate, or loaded from the memory word.

Top module: `dsp_agu`

## Requirements
- R1: After reset, all eight pointer registers, the selector, the page number, the index, the circular base and the circular length are zero, and `ea_valid` is low while `op` is 0.
- R2: Code 13 stores `imm[8:0]` as the page number. Code 1 drives `ea = {page, imm[6:0]}` with `ea_valid` high; the immediate bits above bit 6 have no effect on the address.
- R3: Code 12 stores `imm[2:0]` as the selector, and `cur_ar` shows the selected register. Codes 2 to 7 drive `ea` with the selected register's value before modification, and any update is visible on `cur_ar` after the next clock edge. `ea_valid` is high only for codes 1 to 7, and `ea` is zero otherwise.
- R4: Code 8 loads the selected register with `imm`. Code 9 adds `imm` to it and code 10 subtracts `imm` from it, both modulo 2^16.
- R5: Code 11 loads the selected register with `mem_data`.
- R6: Code 2 leaves the selected register unchanged. Code 3 adds one to it and code 4 subtracts one, each modulo 2^16.
- R7: Code 14 stores `imm` as the index. Code 5 adds the index to the selected register, modulo 2^16.
- R8: Code 15 stores `imm` as the circular base and code 16 stores it as the circular length. With a nonzero length, code 6 sets the register to the base when it is at or beyond base+length-1, and otherwise adds one. With a zero length, code 6 simply adds one.
- R9: Code 7 adds the index to the selected register with carries running from bit 15 toward bit 0; a carry out of bit 0 is dropped. With the index set to N/2 and an N-aligned start, successive accesses visit the N entries in bit-reversed order.
- R10: Only the selected pointer register ever changes. Codes 0 and 17 to 31 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 5 | Operation code for this cycle |
| imm | input | 16 | Immediate / offset operand |
| mem_data | input | 16 | Word read from data memory |
| ea | output | 16 | Effective address for this cycle |
| ea_valid | output | 1 | High when `ea` is a memory access |
| cur_ar | output | 16 | Content of the selected pointer register |
| cur_ptr | output | 3 | Current pointer selector |
| cur_page | output | 9 | Current page number |

## Verification
Several properties are checked on every cycle:
- the paged address formula,
- the pre-modification address on pointer accesses,
- the single steps of one and the immediate load,
- that the selector and page hold unless written,
- that a circular step starting inside the buffer stays inside it.

Other behaviours only show in the bench's scenarios. These are the full reverse-carry visiting order, the wrap at the buffer end, indexed steps across the 16-bit boundary, and the proof that unused codes and non-selected registers stay untouched. The bench shows them by replaying long operation sequences against an arithmetic model and sweeping every page offset.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_DIR   = 5'd1,
        OP_IND   = 5'd2,
        OP_INC   = 5'd3,
        OP_DEC   = 5'd4,
        OP_IDX   = 5'd5,
        OP_CIRC  = 5'd6,
        OP_REV   = 5'd7,
        OP_LDI   = 5'd8,
        OP_ADDI  = 5'd9,
        OP_SUBI  = 5'd10,
        OP_LDM   = 5'd11,
        OP_SPTR  = 5'd12,
        OP_SPAGE = 5'd13,
        OP_SIDX  = 5'd14,
        OP_SBASE = 5'd15,
        OP_SLEN  = 5'd16
    } agu_op_e;

    typedef enum logic [2:0] {
        M_HOLD,
        M_LOAD,
        M_ADD,
        M_SUB,
        M_CIRC,
        M_REV
    } mod_e;
endpackage

// File: rtl/agu_revadd.sv
module agu_revadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] ra, rb, rs;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign ra[i]     = a[W-1-i];
        assign rb[i]     = b[W-1-i];
        assign s[W-1-i]  = rs[i];
    end

    assign rs = ra + rb;
endmodule

// File: rtl/agu_modify.sv
module agu_modify
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  mod_e          mode,
    input  logic [AW-1:0] ar,
    input  logic [AW-1:0] opnd,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    logic [AW:0]   last_w;
    logic [AW-1:0] rev_sum;
    logic          wrap;

    agu_revadd #(.W(AW)) u_rev (
        .a (ar),
        .b (opnd),
        .s (rev_sum)
    );

    always_comb begin
        last_w = {1'b0, base} + {1'b0, len} - {{AW{1'b0}}, 1'b1};
        wrap   = (len != '0) && ({1'b0, ar} >= last_w);
    end

    always_comb begin
        unique case (mode)
            M_LOAD:  nxt = opnd;
            M_ADD:   nxt = ar + opnd;
            M_SUB:   nxt = ar - opnd;
            M_CIRC:  nxt = wrap ? base : ar + {{(AW-1){1'b0}}, 1'b1};
            M_REV:   nxt = rev_sum;
            default: nxt = ar;
        endcase
    end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NREG   = 8,
    parameter int PAGE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              op,
    input  logic [AW-1:0]           imm,
    input  logic [AW-1:0]           mem_data,
    output logic [AW-1:0]           ea,
    output logic                    ea_valid,
    output logic [AW-1:0]           cur_ar,
    output logic [$clog2(NREG)-1:0] cur_ptr,
    output logic [PAGE_W-1:0]       cur_page
);
    localparam int PTR_W = $clog2(NREG);
    localparam int OFF_W = AW - PAGE_W;

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] ar;
        logic [PTR_W-1:0]        ptr;
        logic [PAGE_W-1:0]       page;
        logic [AW-1:0]           idx;
        logic [AW-1:0]           base;
        logic [AW-1:0]           len;
    } agu_state_t;

    agu_state_t    s_d, s_q;
    mod_e          mode;
    logic [AW-1:0] opnd;
    logic          wr_ar;
    logic [AW-1:0] sel_ar;
    logic [AW-1:0] nxt_ar;
    logic [AW-1:0] circ_base;
    logic [AW-1:0] circ_len;

    assign sel_ar    = s_q.ar[s_q.ptr];
    assign circ_base = s_q.base;
    assign circ_len  = s_q.len;

    agu_modify #(.AW(AW)) u_mod (
        .mode (mode),
        .ar   (sel_ar),
        .opnd (opnd),
        .base (s_q.base),
        .len  (s_q.len),
        .nxt  (nxt_ar)
    );

    // decode: address output and modify-unit controls
    always_comb begin
        mode     = M_HOLD;
        opnd     = '0;
        wr_ar    = 1'b0;
        ea       = '0;
        ea_valid = 1'b0;
        case (op)
            OP_DIR: begin
                ea       = {s_q.page, imm[OFF_W-1:0]};
                ea_valid = 1'b1;
            end
            OP_IND: begin
                ea       = sel_ar;
                ea_valid = 1'b1;
            end
            OP_INC, OP_DEC, OP_IDX, OP_CIRC, OP_REV: begin
                ea       = sel_ar;
                ea_valid = 1'b1;
                wr_ar    = 1'b1;
                case (op)
                    OP_INC:  begin mode = M_ADD;  opnd = {{(AW-1){1'b0}}, 1'b1}; end
                    OP_DEC:  begin mode = M_SUB;  opnd = {{(AW-1){1'b0}}, 1'b1}; end
                    OP_IDX:  begin mode = M_ADD;  opnd = s_q.idx; end
                    OP_CIRC: begin mode = M_CIRC; end
                    default: begin mode = M_REV;  opnd = s_q.idx; end
                endcase
            end
            OP_LDI:  begin mode = M_LOAD; opnd = imm;      wr_ar = 1'b1; end
            OP_ADDI: begin mode = M_ADD;  opnd = imm;      wr_ar = 1'b1; end
            OP_SUBI: begin mode = M_SUB;  opnd = imm;      wr_ar = 1'b1; end
            OP_LDM:  begin mode = M_LOAD; opnd = mem_data; wr_ar = 1'b1; end
            default: ;
        endcase
    end

    // next-state
    always_comb begin
        s_d = s_q;
        if (wr_ar) s_d.ar[s_q.ptr] = nxt_ar;
        case (op)
            OP_SPTR:  s_d.ptr  = imm[PTR_W-1:0];
            OP_SPAGE: s_d.page = imm[PAGE_W-1:0];
            OP_SIDX:  s_d.idx  = imm;
            OP_SBASE: s_d.base = imm;
            OP_SLEN:  s_d.len  = imm;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_ar   = sel_ar;
    assign cur_ptr  = s_q.ptr;
    assign cur_page = s_q.page;
endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int PTR_W  = 3,
    parameter int PAGE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op,
    input logic [AW-1:0]     imm,
    input logic [AW-1:0]     ea,
    input logic              ea_valid,
    input logic [AW-1:0]     cur_ar,
    input logic [PTR_W-1:0]  cur_ptr,
    input logic [PAGE_W-1:0] cur_page,
    input logic [AW-1:0]     circ_base,
    input logic [AW-1:0]     circ_len
);
    localparam int OFF_W = AW - PAGE_W;

    logic is_ptr_acc;
    logic in_buf;
    assign is_ptr_acc = (op >= 5'd2) && (op <= 5'd7);
    assign in_buf = (circ_len != '0) && (cur_ar >= circ_base)
                 && ({1'b0, cur_ar} < ({1'b0, circ_base} + {1'b0, circ_len}));

    AST_DIRECT_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DIR) |-> (ea_valid && ea == {cur_page, imm[OFF_W-1:0]})); // R2
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_SPAGE) |=> $stable(cur_page)); // R2
    AST_PTR_EA_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        is_ptr_acc |-> (ea_valid && ea == cur_ar)); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_SPTR) |=> $stable(cur_ptr)); // R3
    AST_LOAD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LDI) |=> (cur_ar == $past(imm))); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> (cur_ar == $past(cur_ar) + 16'd1)); // R6
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC) |=> (cur_ar == $past(cur_ar) - 16'd1)); // R6
    AST_CIRC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CIRC && in_buf) |=> in_buf); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP || op > 5'd16) |=> ($stable(cur_ar) && $stable(cur_ptr))); // R10
endmodule

bind dsp_agu agu_chk #(
    .AW     (AW),
    .PTR_W  ($clog2(NREG)),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .imm       (imm),
    .ea        (ea),
    .ea_valid  (ea_valid),
    .cur_ar    (cur_ar),
    .cur_ptr   (cur_ptr),
    .cur_page  (cur_page),
    .circ_base (circ_base),
    .circ_len  (circ_len)
);

// File: tb/sim_dsp_agu.sv
module sim_dsp_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = 5'd0;
    logic [15:0] imm = '0;
    logic [15:0] mem_data = '0;
    logic [15:0] ea;
    logic        ea_valid;
    logic [15:0] cur_ar;
    logic [2:0]  cur_ptr;
    logic [8:0]  cur_page;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    logic [15:0] m_ar [8];
    logic [2:0]  m_ptr;
    logic [8:0]  m_page;
    logic [15:0] m_idx, m_base, m_len;

    always #5 clk = ~clk;

    dsp_agu u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .mem_data(mem_data),
        .ea(ea), .ea_valid(ea_valid), .cur_ar(cur_ar), .cur_ptr(cur_ptr),
        .cur_page(cur_page)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // carry ripples from bit 15 down to bit 0
    function automatic logic [15:0] rc_add(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        logic        c;
        logic [1:0]  t;
        c = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            t    = {1'b0, a[i]} + {1'b0, b[i]} + {1'b0, c};
            r[i] = t[0];
            c    = t[1];
        end
        return r;
    endfunction

    task automatic step(input logic [4:0] o, input logic [15:0] im,
                        input logic [15:0] md, input string rq);
        logic [15:0] cur, exp_ea;
        logic [16:0] lastv;
        @(negedge clk);
        op = o; imm = im; mem_data = md;
        #1;
        cur = m_ar[m_ptr];
        if (o == 5'd1) begin
            exp_ea = {m_page, im[6:0]};
            chk(ea_valid && ea == exp_ea, rq, "direct ea", {15'd0, ea_valid, ea}, {16'd1, exp_ea});
        end else if (o >= 5'd2 && o <= 5'd7) begin
            chk(ea_valid && ea == cur, rq, "pointer ea", {15'd0, ea_valid, ea}, {16'd1, cur});
        end else begin
            chk(!ea_valid && ea == 16'd0, "R3", "no access", {15'd0, ea_valid, ea}, 32'd0);
        end
        @(posedge clk);
        case (o)
            5'd3:  m_ar[m_ptr] = cur + 16'd1;
            5'd4:  m_ar[m_ptr] = cur - 16'd1;
            5'd5:  m_ar[m_ptr] = cur + m_idx;
            5'd6: begin
                lastv = {1'b0, m_base} + {1'b0, m_len} - 17'd1;
                m_ar[m_ptr] = (m_len != 0 && {1'b0, cur} >= lastv) ? m_base : cur + 16'd1;
            end
            5'd7:  m_ar[m_ptr] = rc_add(cur, m_idx);
            5'd8:  m_ar[m_ptr] = im;
            5'd9:  m_ar[m_ptr] = cur + im;
            5'd10: m_ar[m_ptr] = cur - im;
            5'd11: m_ar[m_ptr] = md;
            5'd12: m_ptr  = im[2:0];
            5'd13: m_page = im[8:0];
            5'd14: m_idx  = im;
            5'd15: m_base = im;
            5'd16: m_len  = im;
            default: ;
        endcase
        #1;
        chk(cur_ar == m_ar[m_ptr], rq, "cur_ar", {16'd0, cur_ar}, {16'd0, m_ar[m_ptr]});
        chk(cur_ptr == m_ptr && cur_page == m_page, rq, "ptr/page",
            {20'd0, cur_ptr, cur_page}, {20'd0, m_ptr, m_page});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_ar[i] = '0;
        m_ptr = '0; m_page = '0; m_idx = '0; m_base = '0; m_len = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(cur_ar == 0 && cur_ptr == 0 && cur_page == 0, "R1", "reset regs",
            {7'd0, cur_ptr, cur_page, cur_ar[12:0]}, 32'd0);
        chk(!ea_valid, "R1", "reset ea_valid", {31'd0, ea_valid}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        for (int r = 0; r < 8; r++) step(5'd12, 16'(r), 16'h0, "R1");

        // R2: page sweep with every offset, junk in upper immediate bits
        for (int p = 0; p < 512; p += 73) begin
            step(5'd13, {7'h55, 9'(p)}, 16'h0, "R2");
            for (int o = 0; o < 128; o++) step(5'd1, {9'h1AB, 7'(o)}, 16'h0, "R2");
        end
        step(5'd13, 16'hFFFF, 16'h0, "R2");
        step(5'd1, 16'h007F, 16'h0, "R2");

        // R3/R4: load each register, reread through pointer access
        for (int r = 0; r < 8; r++) begin
            step(5'd12, 16'(r), 16'h0, "R3");
            step(5'd8, 16'h1000 * 16'(r) + 16'(3 * r), 16'h0, "R4");
        end
        for (int r = 7; r >= 0; r--) begin
            step(5'd12, 16'hFFF8 | 16'(r), 16'h0, "R3");
            step(5'd2, 16'h0, 16'h0, "R3");
        end
        step(5'd12, 16'd5, 16'h0, "R4");
        step(5'd9, 16'hF000, 16'h0, "R4");
        step(5'd10, 16'h7777, 16'h0, "R4");
        step(5'd10, 16'hFFFF, 16'h0, "R4");

        // R5: load from memory
        step(5'd11, 16'h1234, 16'hBEEF, "R5");
        step(5'd2, 16'h0, 16'h0, "R5");

        // R6: step of one across both wrap points
        step(5'd8, 16'hFFFE, 16'h0, "R6");
        repeat (3) step(5'd3, 16'h0, 16'h0, "R6");
        repeat (3) step(5'd4, 16'h0, 16'h0, "R6");

        // R7: indexed across the top
        step(5'd14, 16'h0100, 16'h0, "R7");
        step(5'd8, 16'hFE80, 16'h0, "R7");
        repeat (4) step(5'd5, 16'h0, 16'h0, "R7");

        // R8: circular buffer, lengths 5, 1 and 0
        step(5'd15, 16'd100, 16'h0, "R8");
        step(5'd16, 16'd5, 16'h0, "R8");
        step(5'd8, 16'd100, 16'h0, "R8");
        repeat (12) step(5'd6, 16'h0, 16'h0, "R8");
        step(5'd8, 16'd200, 16'h0, "R8");
        step(5'd6, 16'h0, 16'h0, "R8");
        step(5'd16, 16'd1, 16'h0, "R8");
        repeat (3) step(5'd6, 16'h0, 16'h0, "R8");
        step(5'd16, 16'd0, 16'h0, "R8");
        repeat (2) step(5'd6, 16'h0, 16'h0, "R8");

        // R9: reverse-carry for 8- and 16-point orderings
        step(5'd12, 16'd2, 16'h0, "R9");
        step(5'd14, 16'd4, 16'h0, "R9");
        step(5'd8, 16'h0200, 16'h0, "R9");
        repeat (16) step(5'd7, 16'h0, 16'h0, "R9");
        step(5'd14, 16'd8, 16'h0, "R9");
        step(5'd8, 16'h0300, 16'h0, "R9");
        repeat (20) step(5'd7, 16'h0, 16'h0, "R9");
        step(5'd8, 16'h0000, 16'h0, "R9");
        step(5'd7, 16'h0, 16'h0, "R9");
        chk(cur_ar == 16'h0008, "R9", "rev step 0->8", {16'd0, cur_ar}, 32'h8);

        // R10: inert codes, then reread every register
        step(5'd0, 16'hFFFF, 16'hFFFF, "R10");
        for (int c = 17; c < 32; c++) step(5'(c), 16'hA5A5, 16'h5A5A, "R10");
        for (int r = 0; r < 8; r++) begin
            step(5'd12, 16'(r), 16'h0, "R10");
            step(5'd2, 16'h0, 16'h0, "R10");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            vecs++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule